// File: doc/BRIEF.md
# Paged Short-Address Load/Store Unit

This block executes the short-addressed data-memory instructions of a 16-bit DSP. Each instruction word whose top four bits are 0010 carries an 8-bit immediate offset. The block joins that offset with an 8-bit page register to form a 16-bit data address. Depending on the word, the block then does one of four things: it loads a memory word into a general register, stores a full register, stores the high half of an accumulator, or does nothing apart from advancing the program counter.

All decoding and all port drive are combinational from the instruction word, so a whole instruction completes in the cycle in which it is presented. The register file and the data memory answer in the same cycle. The only state is the page register, which is 8 bits wide and resets to 0x00FF. Software writes it through a dedicated port. A write takes effect at the next clock edge, so an instruction in the same cycle still uses the old page. A read of the page register returns zeros in bits 15:8.

Top module: `dsp_page_ldst`

## Requirements
- R1: After reset, `cfg_rdata` reads 0x00FF.
- R2: When `cfg_we` is high at a clock edge, the page becomes `cfg_wdata[7:0]` and bits 15:8 of the written value are dropped. `cfg_rdata[15:8]` always reads 0. Without `cfg_we` the page holds its value.
- R3: Every memory access uses the address {page, insn[7:0]}. The page used is the value held before any write in the same cycle.
- R4: For a word 0010 0ddd mmmm mmmm (insn[11] = 0), the block raises `mem_re` and `rf_we`, sets `rf_waddr` = 0x18 + insn[10:8], and forwards `mem_rdata` on `rf_wdata`. It does not raise `mem_we`.
- R5: For a word 0010 11ss mmmm mmmm, the block reads register 0x1C + insn[9:8] through `rf_raddr`, raises `mem_we`, and drives `rf_rdata` on `mem_wdata`. It raises neither `rf_we` nor `mem_re`.
- R6: For a word 0010 100s mmmm mmmm, the block behaves as in R5, except that the register read is 0x10 + insn[8], the high half of an accumulator.
- R7: For a word 0010 101x mmmm mmmm, the block raises none of `mem_we`, `mem_re` and `rf_we`.
- R8: Every valid word with insn[15:12] = 0010 raises `pc_inc` for that cycle. This includes the pattern of R7.
- R9: While `insn_valid` is low, or for any word whose top nibble is not 0010, the block raises none of `mem_we`, `mem_re`, `rf_we` and `pc_inc`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| insn_valid | input | 1 | An instruction word is presented this cycle |
| insn | input | 16 | Instruction word |
| cfg_we | input | 1 | Write strobe for the page register |
| cfg_wdata | input | 16 | Write data for the page register (bits 15:8 ignored) |
| cfg_rdata | output | 16 | Page register, zero-extended |
| rf_raddr | output | 5 | Register-file read address for stores |
| rf_rdata | input | 16 | Register-file read data |
| rf_we | output | 1 | Register-file write strobe for loads |
| rf_waddr | output | 5 | Register-file write address |
| rf_wdata | output | 16 | Register-file write data |
| mem_addr | output | 16 | Data-memory address |
| mem_re | output | 1 | Data-memory read strobe |
| mem_rdata | input | 16 | Data-memory read data |
| mem_we | output | 1 | Data-memory write strobe |
| mem_wdata | output | 16 | Data-memory write data |
| pc_inc | output | 1 | Program-counter advance strobe |

## Verification
The bench covers the lowest and highest register selector for each of the three active forms. This shows that the selector field is taken from the right bits and added to the right base. Offsets of 0x00, 0x80 and 0xFE check that the immediate lands in the low address byte unchanged.

Both codes of the unused pattern are tried, to separate a silent advance from a stray write. Words from neighbouring groups are also tried, to show that the top-nibble match is exact.

Directed steps change the page between instructions and in the same cycle as one. This separates the old page from the new one and shows that the upper write bits are dropped.

// File: rtl/dsp_page_ldst.sv
module dsp_page_ldst #(
  parameter int DATA_W = 16,
  parameter int PAGE_W = 8,
  parameter int REG_W  = 5,
  parameter logic [PAGE_W-1:0] PAGE_RST = 8'hFF
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                insn_valid,
  input  logic [DATA_W-1:0]   insn,
  input  logic                cfg_we,
  input  logic [DATA_W-1:0]   cfg_wdata,
  output logic [DATA_W-1:0]   cfg_rdata,
  output logic [REG_W-1:0]    rf_raddr,
  input  logic [DATA_W-1:0]   rf_rdata,
  output logic                rf_we,
  output logic [REG_W-1:0]    rf_waddr,
  output logic [DATA_W-1:0]   rf_wdata,
  output logic [2*PAGE_W-1:0] mem_addr,
  output logic                mem_re,
  input  logic [DATA_W-1:0]   mem_rdata,
  output logic                mem_we,
  output logic [DATA_W-1:0]   mem_wdata,
  output logic                pc_inc
);
  localparam logic [3:0]       GROUP     = 4'b0010;
  localparam logic [REG_W-1:0] LD_BASE   = REG_W'(5'h18);
  localparam logic [REG_W-1:0] ST_BASE   = REG_W'(5'h1C);
  localparam logic [REG_W-1:0] HI_BASE   = REG_W'(5'h10);

  logic [PAGE_W-1:0] page_q;
  logic grp, is_ld, is_st, is_hi;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)      page_q <= PAGE_RST;
    else if (cfg_we) page_q <= cfg_wdata[PAGE_W-1:0];

  assign cfg_rdata = {{(DATA_W-PAGE_W){1'b0}}, page_q};

  assign grp   = insn_valid && (insn[DATA_W-1 -: 4] == GROUP);
  assign is_ld = grp && !insn[11];
  assign is_st = grp && (insn[11:10] == 2'b11);
  assign is_hi = grp && (insn[11:9] == 3'b100);

  assign mem_addr  = {page_q, insn[PAGE_W-1:0]};
  assign mem_re    = is_ld;
  assign mem_we    = is_st || is_hi;
  assign mem_wdata = rf_rdata;
  assign pc_inc    = grp;

  assign rf_we    = is_ld;
  assign rf_wdata = mem_rdata;
  assign rf_waddr = is_ld ? LD_BASE + REG_W'(insn[10:8]) : '0;
  assign rf_raddr = is_st ? ST_BASE + REG_W'(insn[9:8]) :
                    is_hi ? HI_BASE + REG_W'(insn[8])   : '0;

  a_r2_page_holds: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_we |=> $stable(cfg_rdata));
  a_r2_page_loads: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_we |=> cfg_rdata == DATA_W'($past(cfg_wdata[PAGE_W-1:0])));
  a_r3_page_in_addr: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_re || mem_we) |-> mem_addr[2*PAGE_W-1:PAGE_W] == cfg_rdata[PAGE_W-1:0]);
  a_r4_one_direction: assert property (@(posedge clk) disable iff (!rst_n)
    !(mem_we && (rf_we || mem_re)));
  a_r7_unused_silent: assert property (@(posedge clk) disable iff (!rst_n)
    (insn_valid && insn[15:9] == 7'b0010101) |-> (!mem_we && !mem_re && !rf_we && pc_inc));
  a_r9_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !pc_inc |-> (!mem_we && !mem_re && !rf_we));
endmodule

// File: tb/sim_dsp_page_ldst.sv
module sim_dsp_page_ldst;
  logic clk = 0, rst_n = 0;
  logic insn_valid = 0, cfg_we = 0;
  logic [15:0] insn = 0, cfg_wdata = 0, rf_rdata = 16'h3C5A, mem_rdata = 16'hA5C3;
  logic [15:0] cfg_rdata, rf_wdata, mem_addr, mem_wdata;
  logic [4:0]  rf_raddr, rf_waddr;
  logic rf_we, mem_re, mem_we, pc_inc;
  int checks = 0, fails = 0;
  bit done = 0;

  always #5 clk = ~clk;

  dsp_page_ldst u0 (.clk, .rst_n, .insn_valid, .insn, .cfg_we, .cfg_wdata, .cfg_rdata,
    .rf_raddr, .rf_rdata, .rf_we, .rf_waddr, .rf_wdata, .mem_addr, .mem_re,
    .mem_rdata, .mem_we, .mem_wdata, .pc_inc);

  typedef struct packed {
    logic [15:0] word;
    logic we, re, rfwe, pc;
    logic [15:0] addr;
    logic [4:0]  sel;
  } vec_t;

  localparam vec_t VEC [10] = '{
    '{16'h2012, 1'b0, 1'b1, 1'b1, 1'b1, 16'hFF12, 5'h18},
    '{16'h27FE, 1'b0, 1'b1, 1'b1, 1'b1, 16'hFFFE, 5'h1F},
    '{16'h2C00, 1'b1, 1'b0, 1'b0, 1'b1, 16'hFF00, 5'h1C},
    '{16'h2F80, 1'b1, 1'b0, 1'b0, 1'b1, 16'hFF80, 5'h1F},
    '{16'h2833, 1'b1, 1'b0, 1'b0, 1'b1, 16'hFF33, 5'h10},
    '{16'h2944, 1'b1, 1'b0, 1'b0, 1'b1, 16'hFF44, 5'h11},
    '{16'h2A55, 1'b0, 1'b0, 1'b0, 1'b1, 16'h0000, 5'h00},
    '{16'h2B66, 1'b0, 1'b0, 1'b0, 1'b1, 16'h0000, 5'h00},
    '{16'h3012, 1'b0, 1'b0, 1'b0, 1'b0, 16'h0000, 5'h00},
    '{16'h1C12, 1'b0, 1'b0, 1'b0, 1'b0, 16'h0000, 5'h00}
  };

  function automatic string tag_of(logic [15:0] w);
    if (w[15:12] != 4'b0010) return "R9";
    if (!w[11])              return "R4";
    if (w[10])               return "R5";
    if (!w[9])               return "R6";
    return "R7";
  endfunction

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic present(logic v, logic [15:0] w);
    @(negedge clk);
    insn_valid = v;
    insn = w;
    #2;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    repeat (2) @(posedge clk);
    #1 chk("R1 reset page", cfg_rdata, 16'h00FF);
    rst_n = 1;
    present(1'b0, 16'h0000);
    chk("R1 page after release", cfg_rdata, 16'h00FF);

    foreach (VEC[i]) begin
      present(1'b1, VEC[i].word);
      chk({tag_of(VEC[i].word), " R8 strobes"}, {mem_we, mem_re, rf_we, pc_inc},
          {VEC[i].we, VEC[i].re, VEC[i].rfwe, VEC[i].pc});
      if (VEC[i].re) begin
        chk("R3 load address", mem_addr, VEC[i].addr);
        chk("R4 load dest", rf_waddr, VEC[i].sel);
        chk("R4 load data", rf_wdata, mem_rdata);
      end
      if (VEC[i].we) begin
        chk("R3 store address", mem_addr, VEC[i].addr);
        chk({tag_of(VEC[i].word), " store source"}, rf_raddr, VEC[i].sel);
        chk({tag_of(VEC[i].word), " store data"}, mem_wdata, rf_rdata);
      end
    end

    present(1'b0, 16'h2C12);
    chk("R9 invalid quiet", {mem_we, mem_re, rf_we, pc_inc}, 4'b0000);

    @(negedge clk);
    insn_valid = 0;
    cfg_we = 1;
    cfg_wdata = 16'hAB04;
    @(negedge clk);
    cfg_we = 0;
    #2 chk("R2 upper bits dropped", cfg_rdata, 16'h0004);
    present(1'b1, 16'h2C10);
    chk("R3 page 04 store address", mem_addr, 16'h0410);

    @(negedge clk);
    cfg_we = 1;
    cfg_wdata = 16'h1277;
    insn = 16'h2C10;
    #2 chk("R3 old page same cycle", mem_addr, 16'h0410);
    @(negedge clk);
    cfg_we = 0;
    #2 chk("R2 new page next cycle", cfg_rdata, 16'h0077);
    chk("R3 new page address", mem_addr, 16'h7710);
    repeat (2) @(negedge clk);
    chk("R2 page holds", cfg_rdata, 16'h0077);

    present(1'b1, 16'h2A01);
    chk("R7 unused after page change", {mem_we, mem_re, rf_we, pc_inc}, 4'b0001);

    @(negedge clk);
    rst_n = 0;
    #2 chk("R1 reset restores page", cfg_rdata, 16'h00FF);
    rst_n = 1;

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule